// File: doc/BRIEF.md
# Return-Address Call Stack

This block is a small last-in, first-out store of return addresses that stands behind a single register index of a 32-bit register file. When an instruction writes that register, the block pushes the value. When an instruction reads it, the block pops the top entry and hands it back. The register-file decoder raises a read strobe and a write strobe. Both strobes may be high in the same cycle. In that case the pop is applied first and the push second, so the top entry is replaced and the depth stays the same.

The read port is combinational. While the stack holds at least one entry, it shows the top entry. When the stack is empty, it reads as zero. The block has no valid/ready handshake and applies no back-pressure: every strobe is acted on in the cycle it is presented. A strobe that would underflow or overflow the stack is refused instead. The refused access produces a one-cycle error pulse and a sticky error code of 2. From then on the block ignores all accesses until a synchronous clear starts a fresh run.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset, or in the cycle after `clear_i` is sampled high, the stack is empty, `empty_o`=1, `full_o`=0, `err_o`=0 and `err_code_o`=0.
- R2: A write-only access to a non-full stack makes `wr_data_i` the new top and raises the depth by one. `full_o` is 1 exactly when the depth equals DEPTH.
- R3: `rd_data_o` shows the top entry combinationally. A read-only access to a non-empty stack removes that entry, so entries come back in the reverse of the order they were pushed.
- R4: A read and a write in the same cycle on a stack holding at least one entry is legal, including when the stack is full. It replaces the top with `wr_data_i` and leaves the depth unchanged.
- R5: A read while the stack is empty is an error, whether or not a write comes with it.
- R6: A write without a read while the stack is full is an error.
- R7: After an error access, `err_o` is high for exactly the next cycle, and `err_code_o` becomes 2 (stack underflow/overflow). The code holds its value until a clear.
- R8: An error access leaves the depth and every entry unchanged.
- R9: While `err_code_o` is non-zero, read and write strobes have no effect on the stack.
- R10: `clear_i` takes priority over any strobe sampled in the same cycle.
- R11: `rd_data_o` reads as zero while the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear at the start of a run |
| rd_en_i | input | 1 | Read strobe of the mapped register (pop) |
| wr_en_i | input | 1 | Write strobe of the mapped register (push) |
| wr_data_i | input | WIDTH | Value to push |
| rd_data_o | output | WIDTH | Current top entry, zero when empty |
| full_o | output | 1 | Depth equals DEPTH |
| empty_o | output | 1 | Depth is zero |
| err_o | output | 1 | One-cycle pulse after a refused access |
| err_code_o | output | 32 | Sticky error code, 0 = none, 2 = stack underflow/overflow |

## Verification
The bench builds the block with DEPTH=4 and WIDTH=16. At that size it can reach every fill level from empty to full and try all four combinations of the read and write strobes at each level. Every boundary is therefore covered: pop on empty, push on full, read-plus-write on full, and read-plus-write on empty. After every legal step the bench drains the stack and checks the LIFO order. After every refused step it checks the error pulse, confirms that later accesses are ignored, and clears the block.

// File: rtl/ras_pkg.sv
package ras_pkg;
  localparam int unsigned CODE_W = 32;
  typedef enum logic [CODE_W-1:0] {
    RAS_ERR_NONE  = 32'd0,
    RAS_ERR_STACK = 32'd2
  } ras_err_e;
endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             halted_i,
  input  logic             rd_en_i,
  input  logic             wr_en_i,
  output logic [PTR_W-1:0] depth_o,
  output logic [PTR_W-1:0] top_idx_o,
  output logic [PTR_W-1:0] wr_idx_o,
  output logic             wr_go_o,
  output logic             fault_o
);
  logic [PTR_W-1:0] depth_q, depth_d;
  logic is_empty, is_full, under, over, active;

  assign is_empty  = (depth_q == '0);
  assign is_full   = (depth_q == PTR_W'(DEPTH));
  assign under     = rd_en_i & is_empty;
  assign over      = wr_en_i & ~rd_en_i & is_full;
  assign active    = ~clear_i & ~halted_i;
  assign fault_o   = active & (under | over);
  assign top_idx_o = depth_q - 1'b1;

  always_comb begin
    depth_d  = depth_q;
    wr_go_o  = 1'b0;
    wr_idx_o = depth_q;
    if (clear_i) begin
      depth_d = '0;
    end else if (active && !fault_o) begin
      unique case ({rd_en_i, wr_en_i})
        2'b10: depth_d = depth_q - 1'b1;
        2'b01: begin
          depth_d = depth_q + 1'b1;
          wr_go_o = 1'b1;
        end
        2'b11: begin
          wr_idx_o = top_idx_o;
          wr_go_o  = 1'b1;
        end
        default: depth_d = depth_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) depth_q <= '0;
    else         depth_q <= depth_d;
  end

  assign depth_o = depth_q;
endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_go_i,
  input  logic [PTR_W-1:0] wr_idx_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [PTR_W-1:0] rd_idx_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 slot[g] <= '0;
      else if (wr_go_i && wr_idx_i == PTR_W'(g))   slot[g] <= wr_data_i;
    end
  end

  assign rd_data_o = slot[rd_idx_i[IDX_W-1:0]];
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             rd_en_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             err_o,
  output logic [31:0]      err_code_o
);
  import ras_pkg::*;
  localparam int unsigned PTR_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] depth, top_idx, wr_idx;
  logic             wr_go, fault, err_q;
  logic [WIDTH-1:0] top_val;
  ras_err_e         code_q;

  ras_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i),
    .halted_i(code_q != RAS_ERR_NONE),
    .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
    .depth_o(depth), .top_idx_o(top_idx), .wr_idx_o(wr_idx),
    .wr_go_o(wr_go), .fault_o(fault)
  );

  ras_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_go_i(wr_go), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data_i), .rd_idx_i(top_idx), .rd_data_o(top_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= RAS_ERR_NONE;
      err_q  <= 1'b0;
    end else begin
      err_q <= fault;
      if (clear_i)    code_q <= RAS_ERR_NONE;
      else if (fault) code_q <= RAS_ERR_STACK;
    end
  end

  assign empty_o    = (depth == '0);
  assign full_o     = (depth == PTR_W'(DEPTH));
  assign rd_data_o  = empty_o ? '0 : top_val;
  assign err_o      = err_q;
  assign err_code_o = code_q;
endmodule

// File: rtl/ras_chk.sv
module ras_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             rd_en_i,
  input logic             wr_en_i,
  input logic [WIDTH-1:0] wr_data_i,
  input logic [WIDTH-1:0] rd_data_o,
  input logic             full_o,
  input logic             empty_o,
  input logic             err_o,
  input logic [31:0]      err_code_o
);
  logic live, bad;
  assign live = !clear_i && (err_code_o == 32'd0);
  assign bad  = live && ((rd_en_i && empty_o) || (wr_en_i && !rd_en_i && full_o));

  // R10
  clear_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (empty_o && err_code_o == 32'd0));
  // R7
  err_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> (err_o && err_code_o == 32'd2));
  // R7
  err_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  // R8
  err_keeps_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> (full_o == $past(full_o) && empty_o == $past(empty_o) && rd_data_o == $past(rd_data_o)));
  // R2
  push_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && wr_en_i && !rd_en_i && !full_o) |=> (!empty_o && rd_data_o == $past(wr_data_i)));
  // R11
  empty_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (rd_data_o == '0 && !full_o));
  // R9
  halted_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && err_code_o != 32'd0) |=> ($stable(rd_data_o) && $stable(full_o) && $stable(empty_o)));
endmodule

bind ret_addr_stack ras_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .rd_en_i(rd_en_i),
  .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
  .full_o(full_o), .empty_o(empty_o), .err_o(err_o), .err_code_o(err_code_o)
);

// File: tb/ret_addr_stack_tb.sv
module ret_addr_stack_tb;
  localparam int D = 4;
  localparam int W = 16;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 50000;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [W-1:0] wd = '0, rdata;
  logic full, empty, err;
  logic [31:0] code;
  int n_chk = 0, n_fail = 0;
  logic [W-1:0] model [D];
  int depth = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ret_addr_stack #(.DEPTH(D), .WIDTH(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clr), .rd_en_i(rd), .wr_en_i(wr),
    .wr_data_i(wd), .rd_data_o(rdata), .full_o(full), .empty_o(empty),
    .err_o(err), .err_code_o(code)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req, input logic e_err, input logic [31:0] e_code);
    logic [W-1:0] top;
    top = (depth == 0) ? '0 : model[depth-1];
    check({req, " top"}, 32'(rdata), 32'(top));
    check({req, " empty"}, 32'(empty), 32'(depth == 0));
    check({req, " full"}, 32'(full), 32'(depth == D));
    check({req, " err"}, 32'(err), 32'(e_err));
    check({req, " code"}, code, e_code);
  endtask

  // one access: drive after negedge, sample at the following negedge
  task automatic step(input logic c, input logic r, input logic w, input logic [W-1:0] d);
    clr = c; rd = r; wr = w; wd = d;
    @(negedge clk);
    clr = 1'b0; rd = 1'b0; wr = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 reset", 1'b0, 32'd0);
    check("R11 empty reads zero", 32'(rdata), 32'd0);

    for (int lvl = 0; lvl <= D; lvl++) begin
      for (int op = 0; op < 4; op++) begin
        logic r, w, bad;
        logic [W-1:0] nv;
        r = op[1]; w = op[0];
        // R10: clear wins over a simultaneous push
        step(1'b1, 1'b0, 1'b1, 16'hDEAD);
        depth = 0;
        check_state("R10 clear priority", 1'b0, 32'd0);
        for (int k = 0; k < lvl; k++) begin
          nv = W'(16'hA000 + lvl * 256 + op * 16 + k);
          step(1'b0, 1'b0, 1'b1, nv);
          model[depth] = nv; depth++;
          check_state("R2 push", 1'b0, 32'd0);
        end
        nv = W'(16'h5000 + lvl * 16 + op);
        bad = r ? (lvl == 0) : (w && lvl == D);
        step(1'b0, r, w, nv);
        if (bad) begin
          check_state(r ? "R5 R8 underflow" : "R6 R8 overflow", 1'b1, 32'd2);
          step(1'b0, 1'b0, 1'b1, 16'h7777);
          check_state("R7 R9 pulse and halt on push", 1'b0, 32'd2);
          step(1'b0, 1'b1, 1'b0, '0);
          check_state("R9 halt on pop", 1'b0, 32'd2);
        end else begin
          if (r && w) model[depth-1] = nv;
          else if (r) depth--;
          else if (w) begin model[depth] = nv; depth++; end
          check_state((r && w) ? "R4 read-write" : (r ? "R3 pop" : "R2 step"), 1'b0, 32'd0);
          while (depth > 0) begin
            step(1'b0, 1'b1, 1'b0, '0);
            depth--;
            check_state("R3 drain order", 1'b0, 32'd0);
          end
          check("R11 drained reads zero", 32'(rdata), 32'd0);
        end
      end
    end

    step(1'b1, 1'b0, 1'b0, '0);
    depth = 0;
    check_state("R1 final clear", 1'b0, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule